// File: doc/BRIEF.md
# Interrupt Destination Matcher

This block decides which processors in an N-processor cluster receive an inter-processor interrupt. It takes the two words of an interrupt command, the index of the sending processor, and each processor's identity: an 8-bit physical ID, a 32-bit logical-destination register and a 4-bit destination-format code. From these it returns an N-bit target mask and a flag that is high when at least one processor was selected.

Addressing can be physical, with broadcast, or logical, in flat or cluster format. A two-bit shorthand field can bypass the destination byte and pick the sender alone, every processor, or every processor except the sender. For lowest-priority delivery the mask is reduced to one processor: the matching processor with the highest index. The block does not arbitrate priority and does not inject vectors. It only selects targets.

Each command is presented with a one-cycle strobe. The result is registered on that edge and holds until the next strobe.

Top module: `ipi_dest_matcher`

## Requirements
- R1: While reset is held, and after it is released, the target mask and the valid flag are zero until the first strobe.
- R2: With shorthand 00 and destination mode 0 (command-low bit 11), processor i matches when the destination byte (command-high bits 31:24) is 0xFF or equals its physical ID.
- R3: With shorthand 00, destination mode 1 and format code 4'hF (flat), processor i matches when bits 31:24 of its logical-destination register, ANDed with the destination byte, give a nonzero value.
- R4: With shorthand 00, destination mode 1 and format code 4'h0 (cluster), processor i matches when the upper nibble of its logical ID equals the upper nibble of the destination byte and the two lower nibbles AND to a nonzero value.
- R5: With shorthand 00 and destination mode 1, a processor whose format code is neither 4'hF nor 4'h0 never matches.
- R6: Shorthand 01 (command-low bits 19:18) selects only the processor whose index equals the source index.
- R7: Shorthand 10 selects every processor. Shorthand 11 selects every processor except the source.
- R8: When the delivery mode (command-low bits 10:8) is 3'b001, the mask holds only the highest-indexed matching processor, or is zero when nothing matches.
- R9: The valid flag is high exactly when the registered mask is nonzero.
- R10: Mask and flag update on the clock edge that samples the strobe, and they do not change on edges without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_strobe | input | 1 | Command present this cycle |
| cmd_lo | input | 32 | Command low word: shorthand [19:18], destination mode [11], delivery mode [10:8], vector [7:0] |
| cmd_hi | input | 32 | Command high word: destination byte [31:24] |
| src_idx | input | IDX_W | Index of the sending processor |
| phys_ids | input | NUM_CPU*8 | Physical IDs, processor i at [8i+7:8i] |
| logical_regs | input | NUM_CPU*32 | Logical-destination registers, logical ID of processor i at [32i+31:32i+24] |
| dest_fmts | input | NUM_CPU*4 | Destination-format codes, processor i at [4i+3:4i] |
| tgt_mask | output | NUM_CPU | Registered target mask |
| tgt_valid | output | 1 | Registered flag: mask is nonzero |

## Verification
The mask and the flag are due on the first rising edge after the strobe is driven, with one register stage on the path. The bench model computes its expectation on that same edge from the inputs, and both sides are compared half a period later on the falling edge. The model's expectation changes only on a strobe edge, so every cycle without a strobe checks that the outputs hold (R10). Input changes are driven on falling edges, so they are never sampled in the middle of a change.

// File: rtl/ipi_match_pkg.sv
// Package: shared encodings and the decoded command type for the
// interrupt destination matcher. Assumes command fields sit at fixed
// bit positions in a low and a high 32-bit word.
package ipi_match_pkg;

    typedef enum logic [1:0] {
        SH_NONE     = 2'b00,
        SH_SELF     = 2'b01,
        SH_ALL_INCL = 2'b10,
        SH_ALL_EXCL = 2'b11
    } shorthand_e;

    localparam logic [2:0] DLV_LOWEST  = 3'b001;
    localparam logic [3:0] FMT_FLAT    = 4'hF;
    localparam logic [3:0] FMT_CLUSTER = 4'h0;
    localparam logic [7:0] PHYS_BCAST  = 8'hFF;

    typedef struct packed {
        logic [7:0] dest;
        logic       logical;
        shorthand_e sh;
        logic [2:0] dlv;
    } ipi_cmd_t;

endpackage

// File: rtl/ipi_cmd_decode.sv
// Module: pulls the routing fields out of the two command words.
// Assumes the shorthand is at low[19:18], the destination mode at low[11],
// the delivery mode at low[10:8] and the destination byte at high[31:24].
// The vector and the remaining bits are not used for routing.
module ipi_cmd_decode
    import ipi_match_pkg::*;
(
    input  logic [31:0] cmd_lo,
    input  logic [31:0] cmd_hi,
    output ipi_cmd_t    cmd
);

    logic unused_cmd_bits;

    // Field extraction.
    always_comb begin
        cmd.dest    = cmd_hi[31:24];
        cmd.logical = cmd_lo[11];
        cmd.sh      = shorthand_e'(cmd_lo[19:18]);
        cmd.dlv     = cmd_lo[10:8];
    end

    assign unused_cmd_bits = ^{cmd_lo[31:20], cmd_lo[17:12], cmd_lo[7:0], cmd_hi[23:0]};

endmodule

// File: rtl/ipi_cpu_match.sv
// Module: decides whether one processor, at index MY_IDX, is a target of the
// decoded command. Purely combinational. The clock is only for the assertions.
// Assumes the format code 4'hF means flat and 4'h0 means cluster. Any other
// code disables logical matching.
module ipi_cpu_match
    import ipi_match_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int MY_IDX = 0
)(
    input  logic             clk,
    input  logic             rst_n,
    input  ipi_cmd_t         cmd,
    input  logic [IDX_W-1:0] src_idx,
    input  logic [7:0]       phys_id,
    input  logic [7:0]       logical_id,
    input  logic [3:0]       fmt,
    output logic             hit
);

    localparam logic [IDX_W-1:0] MY_IDX_V = IDX_W'(MY_IDX);

    logic phys_hit;
    logic flat_hit;
    logic clus_hit;
    logic log_hit;
    logic is_self;

    // Physical compare, with broadcast.
    always_comb begin
        phys_hit = (cmd.dest == PHYS_BCAST) || (cmd.dest == phys_id);
    end

    // Logical compares for flat and cluster formats.
    always_comb begin
        flat_hit = |(logical_id & cmd.dest);
        clus_hit = (logical_id[7:4] == cmd.dest[7:4]) &&
                   (|(logical_id[3:0] & cmd.dest[3:0]));
        case (fmt)
            FMT_FLAT:    log_hit = flat_hit;
            FMT_CLUSTER: log_hit = clus_hit;
            default:     log_hit = 1'b0;
        endcase
    end

    // Shorthand select.
    always_comb begin
        is_self = (src_idx == MY_IDX_V);
        case (cmd.sh)
            SH_NONE:     hit = cmd.logical ? log_hit : phys_hit;
            SH_SELF:     hit = is_self;
            SH_ALL_INCL: hit = 1'b1;
            SH_ALL_EXCL: hit = !is_self;
            default:     hit = 1'b0;
        endcase
    end

    // R5: an unknown format never yields a logical match.
    assert_bad_fmt_nomatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.sh == SH_NONE && cmd.logical && fmt != FMT_FLAT && fmt != FMT_CLUSTER) |-> !hit);

    // R2: a physical broadcast reaches every processor.
    assert_phys_bcast_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.sh == SH_NONE && !cmd.logical && cmd.dest == PHYS_BCAST) |-> hit);

endmodule

// File: rtl/ipi_lowpri_pick.sv
// Module: keeps only the highest-indexed set bit of the request mask.
// Purely combinational. Assumes the top index has the highest precedence.
module ipi_lowpri_pick #(
    parameter int N = 8
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    logic [N-1:0] above;

    // above[i]: some request with a higher index is set.
    generate
        for (genvar gi = 0; gi < N; gi++) begin : g_above
            if (gi == N - 1) begin : g_top
                assign above[gi] = 1'b0;
            end else begin : g_rest
                assign above[gi] = |req[N-1:gi+1];
            end
        end
    endgenerate

    // Grant the request that has nothing above it.
    always_comb begin
        grant = req & ~above;
    end

    // R8: at most one grant, and only to a requester.
    assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~req) == '0));

    // R8: any request produces a grant.
    assert_grant_when_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> (grant != '0));

endmodule

// File: rtl/ipi_dest_matcher.sv
// Module: top of the interrupt destination matcher. Decodes the command,
// runs one matcher per processor, applies the lowest-priority reduction
// and registers the mask and the valid flag on the strobe.
// Assumes the identity inputs are stable during the strobe cycle.
module ipi_dest_matcher
    import ipi_match_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int IDX_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_strobe,
    input  logic [31:0]             cmd_lo,
    input  logic [31:0]             cmd_hi,
    input  logic [IDX_W-1:0]        src_idx,
    input  logic [NUM_CPU*8-1:0]    phys_ids,
    input  logic [NUM_CPU*32-1:0]   logical_regs,
    input  logic [NUM_CPU*4-1:0]    dest_fmts,
    output logic [NUM_CPU-1:0]      tgt_mask,
    output logic                    tgt_valid
);

    localparam int LID_LSB = 24;

    ipi_cmd_t           cmd;
    logic [NUM_CPU-1:0] raw_mask;
    logic [NUM_CPU-1:0] lp_mask;
    logic [NUM_CPU-1:0] next_mask;
    logic               unused_ldr_bits;

    ipi_cmd_decode u_decode (
        .cmd_lo (cmd_lo),
        .cmd_hi (cmd_hi),
        .cmd    (cmd)
    );

    // One matcher per processor.
    generate
        for (genvar gc = 0; gc < NUM_CPU; gc++) begin : g_cpu
            ipi_cpu_match #(
                .IDX_W  (IDX_W),
                .MY_IDX (gc)
            ) u_match (
                .clk        (clk),
                .rst_n      (rst_n),
                .cmd        (cmd),
                .src_idx    (src_idx),
                .phys_id    (phys_ids[gc*8 +: 8]),
                .logical_id (logical_regs[gc*32 + LID_LSB +: 8]),
                .fmt        (dest_fmts[gc*4 +: 4]),
                .hit        (raw_mask[gc])
            );
        end
    endgenerate

    // The low 24 bits of each logical register are not used for routing.
    always_comb begin
        unused_ldr_bits = 1'b0;
        for (int k = 0; k < NUM_CPU; k++) begin
            unused_ldr_bits = unused_ldr_bits ^ (^logical_regs[k*32 +: LID_LSB]);
        end
    end

    ipi_lowpri_pick #(.N(NUM_CPU)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (raw_mask),
        .grant (lp_mask)
    );

    // Pick the reduced mask for lowest-priority delivery.
    always_comb begin
        next_mask = (cmd.dlv == DLV_LOWEST) ? lp_mask : raw_mask;
    end

    // Result register: loads on the strobe, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_mask  <= '0;
            tgt_valid <= 1'b0;
        end else if (cmd_strobe) begin
            tgt_mask  <= next_mask;
            tgt_valid <= |next_mask;
        end
    end

    // R9: the flag tracks a nonempty mask.
    assert_valid_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid == (tgt_mask != '0));

    // R10: no strobe, no change.
    assert_hold_nostrobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_strobe |=> ($stable(tgt_mask) && $stable(tgt_valid)));

    // R6: self shorthand targets only the source.
    assert_self_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && cmd_lo[19:18] == 2'b01) |=>
        (tgt_mask == (NUM_CPU'(1) << $past(src_idx))));

    // R7: all-excluding-self never targets the source.
    assert_excl_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && cmd_lo[19:18] == 2'b11) |=> !tgt_mask[$past(src_idx)]);

    // R7: all-including-self with fixed delivery targets everyone.
    assert_incl_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && cmd_lo[19:18] == 2'b10 && cmd_lo[10:8] != 3'b001) |=> (&tgt_mask));

    // R8: lowest-priority results carry at most one target.
    assert_lowpri_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && cmd_lo[10:8] == 3'b001) |=> $onehot0(tgt_mask));

endmodule

// File: tb/ipi_dest_matcher_test.sv
// Bench: a behavioural reference, updated on each rising edge, that is
// compared with the outputs on every falling edge. 100 MHz clock.
module ipi_dest_matcher_test;

    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_strobe = 1'b0;
    logic [31:0]   cmd_lo = '0;
    logic [31:0]   cmd_hi = '0;
    logic [IW-1:0] src_idx = '0;
    logic [N*8-1:0]  phys_ids = '0;
    logic [N*32-1:0] logical_regs = '0;
    logic [N*4-1:0]  dest_fmts = '0;
    logic [N-1:0]  tgt_mask;
    logic          tgt_valid;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;
    string cur_req = "R1";
    string exp_tag = "R1";
    logic [N-1:0] exp_mask = '0;

    always #5 clk = ~clk;

    ipi_dest_matcher #(.NUM_CPU(N)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_strobe(cmd_strobe),
        .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .src_idx(src_idx),
        .phys_ids(phys_ids), .logical_regs(logical_regs), .dest_fmts(dest_fmts),
        .tgt_mask(tgt_mask), .tgt_valid(tgt_valid)
    );

    // Reference: routing rules written from the requirements.
    function automatic logic [N-1:0] ref_mask();
        logic [N-1:0] m = '0;
        int dest = cmd_hi[31:24];
        int sh   = cmd_lo[19:18];
        int dlv  = cmd_lo[10:8];
        bit lg   = cmd_lo[11];
        int top  = -1;
        for (int i = 0; i < N; i++) begin
            int pid = phys_ids[i*8 +: 8];
            int lid = logical_regs[i*32+24 +: 8];
            int f   = dest_fmts[i*4 +: 4];
            bit h   = 0;
            if (sh == 1) h = (i == src_idx);
            else if (sh == 2) h = 1;
            else if (sh == 3) h = (i != src_idx);
            else if (!lg) h = (dest == 255) || (dest == pid);
            else if (f == 15) h = ((lid & dest) != 0);
            else if (f == 0) h = (lid / 16 == dest / 16) && (((lid % 16) & (dest % 16)) != 0);
            m[i] = h;
            if (h) top = i;
        end
        if (dlv == 1) begin
            m = '0;
            if (top >= 0) m[top] = 1'b1;
        end
        return m;
    endfunction

    // Model update on each rising edge.
    always @(posedge clk) begin
        started = 1;
        exp_tag = cur_req;
        if (!rst_n) exp_mask = '0;
        else if (cmd_strobe) exp_mask = ref_mask();
    end

    // Compare on each falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (tgt_mask !== exp_mask || tgt_valid !== (exp_mask != '0)) begin
                errors++;
                $display("FAIL %s: mask=%h valid=%b expected mask=%h valid=%b",
                         exp_tag, tgt_mask, tgt_valid, exp_mask, exp_mask != '0);
            end
        end
    end

    task automatic issue(input logic [31:0] lo, input logic [7:0] dest,
                         input int src, input string tag);
        @(negedge clk);
        cur_req = tag;
        cmd_lo = lo;
        cmd_hi = {dest, 24'h0};
        src_idx = IW'(src);
        cmd_strobe = 1'b1;
        @(negedge clk);
        cmd_strobe = 1'b0;
    endtask

    // Command words: bits 19:18 shorthand, 11 mode, 10:8 delivery.
    function automatic logic [31:0] mk(int sh, int lg, int dlv);
        return (32'(sh) << 18) | (32'(lg) << 11) | (32'(dlv) << 8) | 32'h41;
    endfunction

    task automatic set_flat();
        for (int i = 0; i < N; i++) begin
            phys_ids[i*8 +: 8] = 8'(8'h20 + i);
            logical_regs[i*32 +: 32] = {8'(1 << i), 24'h00ABCD};
            dest_fmts[i*4 +: 4] = 4'hF;
        end
    endtask

    task automatic set_cluster(input logic [3:0] f);
        for (int i = 0; i < N; i++) begin
            logical_regs[i*32 +: 32] = {4'(i / 4), 4'(1 << (i % 4)), 24'h0};
            dest_fmts[i*4 +: 4] = f;
        end
    endtask

    initial begin
        set_flat();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        issue(mk(0, 0, 0), 8'h23, 0, "R2");     // physical ID 0x23 -> cpu3
        issue(mk(0, 0, 0), 8'hFF, 0, "R2");     // broadcast
        issue(mk(0, 0, 0), 8'h05, 0, "R9");     // no match: flag low
        issue(mk(0, 1, 0), 8'h81, 0, "R3");     // flat -> cpu0, cpu7
        issue(mk(0, 1, 1), 8'h16, 0, "R8");     // flat lowest -> cpu4
        issue(mk(0, 1, 1), 8'h00, 0, "R8");     // lowest, nothing matches
        issue(mk(0, 0, 1), 8'hFF, 0, "R8");     // broadcast lowest -> cpu7
        set_cluster(4'h0);
        issue(mk(0, 1, 0), 8'h15, 0, "R4");     // cluster 1 -> cpu4, cpu6
        issue(mk(0, 1, 0), 8'h03, 0, "R4");     // cluster 0 -> cpu0, cpu1
        issue(mk(0, 1, 0), 8'h20, 0, "R4");     // empty lower nibble
        issue(mk(0, 1, 1), 8'h1F, 0, "R8");     // cluster lowest -> cpu7
        set_cluster(4'h5);
        issue(mk(0, 1, 0), 8'hFF, 0, "R5");     // unknown format: none
        dest_fmts[3*4 +: 4] = 4'hF;
        issue(mk(0, 1, 0), 8'hFF, 0, "R5");     // only flat cpu3
        issue(mk(0, 0, 0), 8'h26, 0, "R5");     // physical still works
        set_flat();
        for (int s = 0; s < N; s++) issue(mk(1, 0, 0), 8'h00, s, "R6");
        issue(mk(1, 1, 1), 8'hFF, 5, "R6");
        issue(mk(2, 0, 0), 8'h00, 3, "R7");
        issue(mk(3, 0, 0), 8'h00, 2, "R7");
        issue(mk(3, 0, 1), 8'h00, 7, "R7");     // excl + lowest -> cpu6
        issue(mk(2, 0, 1), 8'h00, 0, "R8");
        // Changing inputs without a strobe leaves the outputs unchanged.
        @(negedge clk);
        cur_req = "R10";
        cmd_lo = mk(2, 0, 0);
        src_idx = 3'd1;
        repeat (4) @(negedge clk);
        // A reset in the middle of operation clears the outputs again.
        cur_req = "R1";
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule